// File: doc/BRIEF.md
# Manchester Bi-Phase Serial Word Transmitter

This block takes one parallel data word and sends it as a single serial bus word in Manchester II bi-phase code. A frame lasts 20 bit times. It opens with a sync pattern three bit times long, then sends the data bits most significant bit first, and ends with one odd-parity bit. The sync pattern is not Manchester coded. It has one level change, at its midpoint, and the order of its two levels tells the receiver whether the word is a command/status word or a data word.

The system clock runs at an even multiple of the bit rate. That multiple is the parameter `OVS`, which defaults to 16, giving 16 clocks per 1 µs bit at 16 MHz. A counter measures half-bit intervals. The host presents a word and a sync-type select, and raises `start` while `ready` is high. The block captures both values on that edge and drives a complementary pair of line outputs with an enable. `ready` stays low for the whole frame until its last clock. A start given in that last clock chains the next word with no idle gap.

Top module: `mtx_word_tx`

## Requirements
- R1: After reset, and between words when no start is pending, `tx_en` is 0, `tx_pos` and `tx_neg` are both 0, and `ready` is 1.
- R2: A `start` pulse while `ready` is 0 is ignored. The frame in flight continues unchanged.
- R3: After an accepted start, the frame occupies exactly 40 half-bits of OVS/2 clocks each, which is 320 clocks by default. `tx_en` is 1 for all of them. `ready` is 0 for every clock of the frame except the last one, where it is 1.
- R4: With `sync_cmd`=1 the frame opens with 3 half-bits of `tx_pos` high, then 3 half-bits low. With `sync_cmd`=0 the order is reversed: 3 low, then 3 high.
- R5: Half-bits 6 to 37 carry the data bits, bit DW-1 first. A 1 is sent as high then low, and a 0 as low then high, so each data bit changes level at its midpoint.
- R6: Half-bits 38 and 39 carry a parity bit, coded the same way as a data bit. Its value makes the number of ones across the data bits and the parity bit odd.
- R7: While `tx_en` is 1, `tx_neg` is always the complement of `tx_pos`.
- R8: A start given in the final clock of a frame, while `ready` is 1, begins the next frame's sync on the very next clock, with no idle clock between the frames.
- R9: The data word and the sync type are captured when the start is accepted. Changes on `word_in` or `sync_cmd` during the frame do not alter it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, OVS times the bit rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request to send; taken only while ready is high |
| word_in | input | DW | Parallel word to send |
| sync_cmd | input | 1 | 1 = command/status sync, 0 = data sync |
| ready | output | 1 | Block can take a start in this clock |
| tx_pos | output | 1 | Positive line drive |
| tx_neg | output | 1 | Negative line drive, complement of tx_pos while enabled |
| tx_en | output | 1 | Line driver enable, high during a frame |

## Verification
The bench builds the block with its defaults, DW=16 and OVS=16. This gives eight-clock half-bits, so the bench can compare every clock of a full 320-clock frame against a level predicted from the half-bit index. With these values, the last-clock ready window and the chained start are each a single clock, so both can be checked exactly. The same holds for a start attempt made in the middle of a frame. The data patterns include all-ones, all-zeros and a single set bit, which drive the parity bit to both of its values.

// File: rtl/mtx_pkg.sv
package mtx_pkg;
   // sync occupies this many half-bits per level
   localparam int SYNC_HALF = 3;

   // odd parity over a word: result makes total ones odd
   function automatic logic odd_par16(input logic [15:0] w);
      return ~(^w);
   endfunction

   typedef enum logic {
      SYNC_DATA = 1'b0,
      SYNC_CMD  = 1'b1
   } sync_e;
endpackage

// File: rtl/mtx_timer.sv
module mtx_timer #(
   parameter int OVS     = 16,
   parameter int WORD_HB = 40,
   localparam int HALF   = OVS / 2,
   localparam int HB_W   = $clog2(WORD_HB)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            go,
   output logic            run,
   output logic [HB_W-1:0] hb_idx,
   output logic            last
);
   logic half_end;

   generate
      if (HALF == 1) begin : g_nocnt
         assign half_end = 1'b1;
      end else begin : g_cnt
         localparam int CW = $clog2(HALF);
         logic [CW-1:0] cnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                cnt <= '0;
            else if (go)               cnt <= '0;
            else if (run) begin
               if (cnt == CW'(HALF - 1)) cnt <= '0;
               else                     cnt <= cnt + 1'b1;
            end
         end
         assign half_end = (cnt == CW'(HALF - 1));
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run    <= 1'b0;
         hb_idx <= '0;
      end else if (go) begin
         run    <= 1'b1;
         hb_idx <= '0;
      end else if (run && half_end) begin
         if (hb_idx == HB_W'(WORD_HB - 1)) begin
            run    <= 1'b0;
            hb_idx <= '0;
         end else begin
            hb_idx <= hb_idx + 1'b1;
         end
      end
   end

   assign last = run && half_end && (hb_idx == HB_W'(WORD_HB - 1));

   // R3
   hb_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      run |-> (hb_idx < HB_W'(WORD_HB)));
endmodule

// File: rtl/mtx_framer.sv
module mtx_framer #(
   parameter int DW      = 16,
   parameter int WORD_HB = 40,
   localparam int HB_W   = $clog2(WORD_HB),
   localparam int IW     = $clog2(DW)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            load,
   input  logic [DW-1:0]   data_in,
   input  logic            cmd_in,
   input  logic            run,
   input  logic [HB_W-1:0] hb_idx,
   output logic            level
);
   import mtx_pkg::*;
   localparam int DATA_HB0 = 2 * SYNC_HALF;
   localparam int PAR_HB   = DATA_HB0 + 2 * DW;

   logic [DW-1:0] data_q;
   logic          cmd_q;
   logic          par_q;
   logic [IW-1:0] sel;
   logic          bv;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_q <= '0;
         cmd_q  <= 1'b0;
         par_q  <= 1'b0;
      end else if (load) begin
         data_q <= data_in;
         cmd_q  <= cmd_in;
         par_q  <= ~(^data_in);
      end
   end

   always_comb begin
      sel   = IW'(DW - 1 - ((int'(hb_idx) - DATA_HB0) >>> 1));
      bv    = data_q[sel];
      level = 1'b0;
      if (int'(hb_idx) < SYNC_HALF)       level = cmd_q;
      else if (int'(hb_idx) < DATA_HB0)   level = ~cmd_q;
      else if (int'(hb_idx) < PAR_HB)     level = hb_idx[0] ? ~bv : bv;
      else                                level = hb_idx[0] ? ~par_q : par_q;
   end

   // R5
   mid_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run && $past(run) && (hb_idx != $past(hb_idx)) && hb_idx[0]
       && (int'(hb_idx) > DATA_HB0)) |-> (level != $past(level)));
endmodule

// File: rtl/mtx_word_tx.sv
module mtx_word_tx #(
   parameter int DW  = 16,
   parameter int OVS = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [DW-1:0] word_in,
   input  logic          sync_cmd,
   output logic          ready,
   output logic          tx_pos,
   output logic          tx_neg,
   output logic          tx_en
);
   import mtx_pkg::*;
   localparam int WORD_HB = 2 * SYNC_HALF + 2 * DW + 2;
   localparam int HB_W    = $clog2(WORD_HB);

   generate
      if ((OVS < 2) || (OVS % 2 != 0)) begin : g_bad_ovs
         $error("OVS must be even and at least 2");
      end
      if (DW < 2) begin : g_bad_dw
         $error("DW must be at least 2");
      end
   endgenerate

   logic            run;
   logic            last;
   logic            accept;
   logic            level;
   logic [HB_W-1:0] hb_idx;

   assign ready  = !run || last;
   assign accept = start && ready;

   mtx_timer #(.OVS(OVS), .WORD_HB(WORD_HB)) u_timer (
      .clk(clk), .rst_n(rst_n), .go(accept),
      .run(run), .hb_idx(hb_idx), .last(last)
   );

   mtx_framer #(.DW(DW), .WORD_HB(WORD_HB)) u_framer (
      .clk(clk), .rst_n(rst_n), .load(accept),
      .data_in(word_in), .cmd_in(sync_cmd),
      .run(run), .hb_idx(hb_idx), .level(level)
   );

   assign tx_en  = run;
   assign tx_pos = run & level;
   assign tx_neg = run & ~level;

   // R1
   idle_lines_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !tx_en |-> (!tx_pos && !tx_neg && ready));
   // R7
   complement_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_en |-> (tx_pos != tx_neg));
   // R3
   accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> (tx_en && !ready));
   // R2
   no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !ready && (hb_idx != '0)) |=> (tx_en && (hb_idx != '0)));
endmodule

// File: tb/tb_mtx_word_tx.sv
module tb_mtx_word_tx;
   localparam int CLK_PERIOD = 10;
   localparam int DW  = 16;
   localparam int OVS = 16;
   localparam int HALF = OVS / 2;
   localparam int NCLK = 40 * HALF;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic [DW-1:0] word_in = '0;
   logic sync_cmd = 1'b0;
   logic ready, tx_pos, tx_neg, tx_en;
   int total = 0;
   int bad = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   mtx_word_tx #(.DW(DW), .OVS(OVS)) dut (
      .clk(clk), .rst_n(rst_n), .start(start), .word_in(word_in),
      .sync_cmd(sync_cmd), .ready(ready), .tx_pos(tx_pos),
      .tx_neg(tx_neg), .tx_en(tx_en)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic logic exp_lvl(input logic [15:0] d, input logic c, input int h);
      logic b;
      if (h < 3) return c;
      if (h < 6) return !c;
      if (h < 38) begin
         b = d[15 - (h - 6) / 2];
         return (h % 2 == 0) ? b : !b;
      end
      b = ~(^d);
      return (h % 2 == 0) ? b : !b;
   endfunction

   // idle state: R1
   task automatic check_idle(input string tag);
      check(!tx_en && !tx_pos && !tx_neg && ready, "R1", tag,
            {tx_en, tx_pos, tx_neg, ready}, 4'b0001);
   endtask

   // drive start at a negedge; returns at the k=0 sample point
   task automatic begin_word(input logic [15:0] d, input logic c);
      start = 1'b1; word_in = d; sync_cmd = c;
      @(negedge clk);
      start = 1'b0;
   endtask

   // walk one frame clock by clock: R3 R4 R5 R6 R7, optional R2/R9 intrusion, R8 chain
   task automatic send_word(input logic [15:0] d, input logic c, input bit intrude,
                            input bit chain, input logic [15:0] nd, input logic nc,
                            input string req);
      int wk = -1; int wact = 0; int wexp = 0;
      int rk = -1; int ract = 0;
      for (int k = 0; k < NCLK; k++) begin
         logic e;
         e = exp_lvl(d, c, k / HALF);
         if (wk < 0 && (tx_pos !== e || tx_neg !== !e || tx_en !== 1'b1)) begin
            wk = k; wact = {tx_en, tx_pos, tx_neg}; wexp = {1'b1, e, !e};
         end
         if (rk < 0 && ready !== (k == NCLK - 1)) begin
            rk = k; ract = ready;
         end
         if (intrude && k == 100) begin
            start = 1'b1; word_in = ~d; sync_cmd = !c;
         end
         if (intrude && k == 101) start = 1'b0;
         if (chain && k == NCLK - 1) begin
            start = 1'b1; word_in = nd; sync_cmd = nc;
         end
         @(negedge clk);
      end
      start = 1'b0;
      check(wk < 0, req, $sformatf("waveform (first bad clock %0d)", wk), wact, wexp);
      check(rk < 0, "R3", $sformatf("ready window (first bad clock %0d)", rk), ract, !ract);
   endtask

   task automatic t_reset();
      check_idle("reset state");
   endtask

   task automatic t_cmd_word();
      begin_word(16'hA5C3, 1'b1);
      send_word(16'hA5C3, 1'b1, 0, 0, '0, 1'b0, "R4 R5 R7 cmd sync");
      check_idle("idle after cmd word");
   endtask

   task automatic t_data_word();
      begin_word(16'h3C96, 1'b0);
      send_word(16'h3C96, 1'b0, 0, 0, '0, 1'b0, "R4 R5 data sync");
      check_idle("idle after data word");
   endtask

   task automatic t_parity();
      begin_word(16'hFFFF, 1'b1);
      send_word(16'hFFFF, 1'b1, 0, 0, '0, 1'b0, "R6 all ones");
      begin_word(16'h0000, 1'b0);
      send_word(16'h0000, 1'b0, 0, 0, '0, 1'b0, "R6 all zeros");
      begin_word(16'h0100, 1'b1);
      send_word(16'h0100, 1'b1, 0, 0, '0, 1'b0, "R6 single one");
      check_idle("idle after parity words");
   endtask

   task automatic t_back_to_back();
      begin_word(16'h1234, 1'b1);
      send_word(16'h1234, 1'b1, 0, 1, 16'hFEDC, 1'b0, "R8 first word");
      check(tx_en === 1'b1, "R8", "no gap after chained start", tx_en, 1);
      send_word(16'hFEDC, 1'b0, 0, 0, '0, 1'b0, "R8 second word");
      check_idle("idle after chain");
   endtask

   task automatic t_ignore_start();
      begin_word(16'h5A0F, 1'b0);
      send_word(16'h5A0F, 1'b0, 1, 0, '0, 1'b0, "R2 R9 start ignored");
      check_idle("idle after ignored start");
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      bad++; total++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_cmd_word();
      t_data_word();
      t_parity();
      t_back_to_back();
      t_ignore_start();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule